// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low interrupt pin and raises an interrupt request toward the CPU's priority logic. The pin passes through a two-stage synchronizer. A falling edge on the synchronized level sets a pending latch. The synchronized level is also brought out so that the CPU can branch on the pin state. A byte-wide control/status register on a simple CPU bus holds a mask, a trigger-mode select and a pending flag. Writing a 1 to a strobe bit in that register gives a software clear.

There are two trigger modes. In edge mode, an acknowledge clears the pending latch at once. The acknowledge is either a vector-fetch strobe from the CPU or the software clear. In edge-plus-level mode, the latch stays set until two things have both happened, in either order: an acknowledge has arrived and the synchronized pin has returned high. The local mask only hides the request output. The latch behind it keeps its state, so a masked interrupt is delivered once the mask is removed.

Top module: `ext_irq_ctrl`

## Requirements
- R1: `pin_level` follows `irq_pin_n` two clock edges after the pin changes. A falling edge of the pin sets the pending latch, and `irq_req` rises four clock edges after the pin falls when the mask is 0.
- R2: With the mode bit (bit 0) at 0, an acknowledge clears the pending latch, and `irq_req` falls one edge after the acknowledge edge even while the pin is still low. The acknowledge is either a one-cycle `vec_ack` or a register write with data bit 2 set.
- R3: With the mode bit at 1, an acknowledge given while the synchronized pin is low leaves the request set. The request clears once the pin is high and an acknowledge has been seen, in either order. Until both have happened, the request stays set.
- R4: When a new falling edge and an acknowledge reach the latch in the same cycle, the latch stays set.
- R5: With the mask bit (bit 1) at 1, `irq_req` is 0 and the pending flag still reads 1. Clearing the mask makes `irq_req` rise again one edge after the write.
- R6: A read returns the register value on `bus_rdata` one edge after the strobe, laid out as follows: bits 7..4 read 0, bit 3 is the pending flag, bit 2 (the acknowledge strobe) reads 0, bit 1 is the mask, and bit 0 is the mode. A write updates only bits 1 and 0.
- R7: A synchronous reset clears the pending latch, the mask, the mode and `irq_req`, even while the pin is held low. A pin held low through reset raises no request afterwards.
- R8: In edge mode, a pin that is held low after its request has been cleared raises no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_sel | input | 1 | Register address match |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe |
| irq_req | output | 1 | Registered interrupt request to priority logic |
| pin_level | output | 1 | Synchronized pin level for branch-on-pin instructions |

## Verification
The case that is hardest to reach is an acknowledge that lands in the same cycle as a fresh falling edge while an older request is still pending. To bring it about, the bench first leaves a request set, raises the pin and lets the synchronizer settle, and then lowers the pin again. It waits exactly two edges, which places the edge detector's output in the following cycle, and pulses `vec_ack` in that cycle. A sweep over both modes, both acknowledge sources and both orderings of acknowledge and pin release checks the either-order clearing rule.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic level
);
  logic [STAGES-1:0] shift_q;

  // Reset value 0 so that a pin held low through reset shows no falling edge.
  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-2:0], pin_n};
  end

  assign level = shift_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             flag,
  output logic             imask,
  output logic             mode,
  output logic             sw_ack,
  output logic [REG_W-1:0] rdata
);
  logic wr_hit;
  assign wr_hit = sel & wr;
  assign sw_ack = wr_hit & wdata[BIT_ACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      imask <= 1'b0;
      mode  <= 1'b0;
    end else if (wr_hit) begin
      imask <= wdata[BIT_MASK];
      mode  <= wdata[BIT_MODE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel & rd) begin
      rdata           <= '0;
      rdata[BIT_FLAG] <= flag;
      rdata[BIT_MASK] <= imask;
      rdata[BIT_MODE] <= mode;
    end
  end
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic mode,
  input  logic ack,
  output logic pend
);
  logic prev_q;
  logic acked_q;
  logic fall;
  logic acked_any;

  assign fall      = prev_q & ~level;
  assign acked_any = acked_q | ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pend    <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (fall) begin
        pend    <= 1'b1;
        acked_q <= 1'b0;
      end else if (pend) begin
        if (!mode) begin
          if (ack) pend <= 1'b0;
          acked_q <= 1'b0;
        end else if (acked_any && level) begin
          pend    <= 1'b0;
          acked_q <= 1'b0;
        end else begin
          acked_q <= acked_any;
        end
      end else begin
        acked_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pin_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             vec_ack,
  output logic             irq_req,
  output logic             pin_level
);
  logic level_s;
  logic pend_q;
  logic imask_q;
  logic mode_q;
  logic sw_ack;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(irq_pin_n), .level(level_s)
  );

  irq_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .flag(pend_q), .imask(imask_q), .mode(mode_q),
    .sw_ack(sw_ack), .rdata(bus_rdata)
  );

  irq_event_latch u_latch (
    .clk(clk), .rst(rst), .level(level_s), .mode(mode_q),
    .ack(sw_ack | vec_ack), .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= pend_q & ~imask_q;
  end

  assign pin_level = level_s;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic level,
  input logic mode,
  input logic imask,
  input logic pend,
  input logic irq_req,
  input logic vec_ack
);
  // R5
  mask_hides_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(pend && !imask));

  // R1
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> ($past(level) == 1'b0 && $past(level, 2) == 1'b1));

  // R3
  level_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && pend && !level) |=> pend);

  // R2
  edge_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && pend && vec_ack && !(!level && $past(level))) |=> !pend);

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!pend && !irq_req && !mode && !imask));
endmodule

bind ext_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .level(pin_level), .mode(mode_q), .imask(imask_q),
  .pend(pend_q), .irq_req(irq_req), .vec_ack(vec_ack)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_pin_n = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       vec_ack = 1'b0;
  logic       irq_req;
  logic       pin_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vec_ack(vec_ack), .irq_req(irq_req),
    .pin_level(pin_level)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_reg(output logic [7:0] v);
    bus_sel = 1'b1; bus_rd = 1'b1;
    tick(1);
    bus_sel = 1'b0; bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse_vec;
    vec_ack = 1'b1;
    tick(1);
    vec_ack = 1'b0;
  endtask

  task automatic do_ack(input bit sw, input bit md);
    if (sw) wr_reg({5'b0, 1'b1, 1'b0, md});
    else    pulse_vec();
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    tick(3); rst = 1'b0; tick(3);
    // R7 reset state
    check("R7 irq_req after reset", {7'b0, irq_req}, 8'h00);
    rd_reg(v); check("R7 register after reset", v, 8'h00);
    check("R1 pin_level idle", {7'b0, pin_level}, 8'h01);

    // R1 latency of the falling edge
    irq_pin_n = 1'b0;
    tick(2); check("R1 pin_level after two edges", {7'b0, pin_level}, 8'h00);
    tick(1); check("R1 irq_req not yet", {7'b0, irq_req}, 8'h00);
    tick(1); check("R1 irq_req after four edges", {7'b0, irq_req}, 8'h01);
    rd_reg(v); check("R6 flag read", v, 8'h08);

    // R2 clear while low, R8 no re-trigger from a held level
    pulse_vec(); tick(1);
    check("R2 vec_ack clears in edge mode", {7'b0, irq_req}, 8'h00);
    tick(5);
    check("R8 held low no new request", {7'b0, irq_req}, 8'h00);
    rd_reg(v); check("R8 flag stays clear", v, 8'h00);
    irq_pin_n = 1'b1; tick(4);

    // R6 write only bits 1:0
    wr_reg(8'hF3); rd_reg(v); check("R6 write/read layout", v, 8'h03);
    wr_reg(8'h00);

    // Sweep: mode x ack source x ordering (R2, R3)
    for (int md = 0; md < 2; md++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int ord = 0; ord < 2; ord++) begin
          wr_reg({7'b0, md[0]});
          irq_pin_n = 1'b0; tick(4);
          check("R1 sweep request set", {7'b0, irq_req}, 8'h01);
          if (ord == 0) begin
            do_ack(sw[0], md[0]); tick(1);
            check(md ? "R3 ack while low keeps request" : "R2 ack clears while low",
                  {7'b0, irq_req}, {7'b0, md[0]});
            irq_pin_n = 1'b1; tick(4);
            check("R3 clears after release", {7'b0, irq_req}, 8'h00);
          end else begin
            irq_pin_n = 1'b1; tick(4);
            check("R3 release alone keeps request", {7'b0, irq_req}, 8'h01);
            do_ack(sw[0], md[0]); tick(1);
            check("R3 ack after release clears", {7'b0, irq_req}, 8'h00);
          end
          rd_reg(v);
          check("R6 ack bit reads 0", v, {7'b0, md[0]});
          tick(2);
        end
      end
    end
    wr_reg(8'h00);

    // R5 mask hides without clearing
    irq_pin_n = 1'b0; tick(4);
    wr_reg(8'h02); tick(1);
    check("R5 masked request hidden", {7'b0, irq_req}, 8'h00);
    rd_reg(v); check("R5 flag kept under mask", v, 8'h0A);
    wr_reg(8'h00); tick(1);
    check("R5 request returns on unmask", {7'b0, irq_req}, 8'h01);
    pulse_vec(); irq_pin_n = 1'b1; tick(4);

    // R4 new edge and acknowledge in the same cycle
    irq_pin_n = 1'b0; tick(4);
    irq_pin_n = 1'b1; tick(4);
    irq_pin_n = 1'b0; tick(2);
    pulse_vec(); tick(1);
    check("R4 edge beats ack", {7'b0, irq_req}, 8'h01);
    rd_reg(v); check("R4 flag set", v, 8'h08);
    pulse_vec(); irq_pin_n = 1'b1; tick(4);

    // R7 reset with pin held low in level mode
    wr_reg(8'h01);
    irq_pin_n = 1'b0; tick(4);
    check("R7 request before reset", {7'b0, irq_req}, 8'h01);
    rst = 1'b1; tick(2); rst = 1'b0; tick(6);
    check("R7 no request after reset, pin low", {7'b0, irq_req}, 8'h00);
    rd_reg(v); check("R7 mode and flag cleared", v, 8'h00);
    check("R1 pin_level low after reset", {7'b0, pin_level}, 8'h00);
    irq_pin_n = 1'b1; tick(4);

    finish_run();
  end
endmodule